// File: doc/BRIEF.md
# MDIO Command Register Master

This block is a management-interface master for an external Ethernet PHY. Software controls it through one 32-bit command/status word. A single write to that word carries all of the transaction: the PHY and register addresses, the direction, and for writes the 16-bit payload. The same write can also launch the transaction. The block then builds a clause-22 frame, shifts it out on MDC/MDIO and holds the launch bit at 1 until the frame ends.

A read operation works the same way. The master lets go of MDIO for the turnaround and the data phase, and samples the PHY's 16 reply bits on rising MDC edges. When the launch bit drops, the reply is in the low half of the command word. Software waits for the frame to end by reading the word until bit 31 is 0. MDC comes from the system clock through a parameterised divider (`HALF_DIV` system cycles per MDC half period) and stays low between frames.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the command word reads 0x0000_0000, MDC is low and `mdio_oe` is low.
- R2: A write with bit 31 = 1 while idle launches a frame. Bit 31 reads 1 from the following cycle. It stays at 1 for exactly 64 × 2 × `HALF_DIV` system cycles, then reads 0.
- R3: The MDIO bits for a write (bit 30 = 0) are sent MSB first, one bit per MDC period: 32 ones, start 01, opcode 01, PHY address (word bits 25:21), register address (word bits 20:16), turnaround 10, then data (word bits 15:0). `mdio_oe` is high for all 64 bits.
- R4: For a read (bit 30 = 1) the first 46 bits are driven as 32 ones, start 01, opcode 10, PHY address and register address. `mdio_oe` is low for the last 18 bits (turnaround and data).
- R5: In a read frame, `mdio_i` is sampled at the rising MDC edges of the 16 data bits, MSB first. Once bit 31 has cleared, the word's bits 15:0 return the 16 sampled bits.
- R6: A write to the word while bit 31 reads 1 is ignored. Bits 30:16 stay unchanged, the frame in flight is not altered, and no second frame follows.
- R7: A write with bit 31 = 0 while idle stores bit 30 and bits 25:0 without launching a frame. MDC stays low, and the stored fields read back.
- R8: While no frame is running, MDC is low and `mdio_oe` is low. `mdio_o` and `mdio_oe` change only while MDC is low.
- R9: Bits 29:26 of the word always read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the command word |
| reg_wr_data | input | 32 | Value written to the command word |
| reg_rd_data | output | 32 | Current command/status word (bit 31 is the live busy flag) |
| mdc | output | 1 | Management clock toward the PHY |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable (low releases the line) |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The hardest case to reach from the ports is a register write that lands in the middle of a frame. The bench issues a second, different command about twenty cycles after a launch, while bit 31 is still set. It then confirms three things: the captured MDIO stream is the first command's frame, the stored fields read back unchanged, and MDC stays low afterwards. Read data also depends on correct phase. A bench PHY model counts MDC rising edges and changes `mdio_i` only on falling edges. That way a sample taken one bit early or late shows up as a shifted value in bits 15:0.

// File: rtl/mdio_cmd_pkg.sv
`timescale 1ns/1ps
package mdio_cmd_pkg;

    localparam int FRAME_BITS = 64;
    localparam int TA_FIRST   = 46;   // first turnaround bit index
    localparam int DATA_FIRST = 48;   // first data bit index
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } mdio_cmd_t;

    function automatic mdio_cmd_t decode_word(input logic [31:0] w);
        mdio_cmd_t c;
        c.rd    = w[30];
        c.phy   = w[25:21];
        c.regad = w[20:16];
        c.data  = w[15:0];
        return c;
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        logic [1:0]  op;
        logic [1:0]  ta;
        logic [15:0] pay;
        op  = c.rd ? 2'b10 : 2'b01;
        ta  = c.rd ? 2'b00 : 2'b10;
        pay = c.rd ? 16'h0000 : c.data;
        return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regad, ta, pay};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_st_t;

    gen_st_t s_d, s_q;
    logic    at_end;

    always_comb begin
        s_d    = s_q;
        at_end = (s_q.cnt == CW'(HALF_DIV - 1));
        if (!run) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (at_end) begin
            s_d.cnt = '0;
            s_d.mdc = ~s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        rise_tick = run && at_end && !s_q.mdc;
        fall_tick = run && at_end &&  s_q.mdc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc = s_q.mdc;
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
    import mdio_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        running,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdio_o,
    output logic        mdio_oe
);
    typedef struct packed {
        logic                  running;
        logic                  rd;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] shreg;
        logic [15:0]           cap;
    } eng_st_t;

    eng_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (!s_q.running) begin
            if (start) begin
                s_d.running = 1'b1;
                s_d.rd      = cmd.rd;
                s_d.idx     = '0;
                s_d.shreg   = build_frame(cmd);
            end
        end else begin
            if (rise_tick && s_q.rd && (s_q.idx >= IDX_W'(DATA_FIRST)))
                s_d.cap = {s_q.cap[14:0], mdio_i};
            if (fall_tick) begin
                if (s_q.idx == IDX_W'(FRAME_BITS - 1)) begin
                    s_d.running = 1'b0;
                    done        = 1'b1;
                end else begin
                    s_d.idx   = s_q.idx + 1'b1;
                    s_d.shreg = {s_q.shreg[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign running = s_q.running;
    assign rd_data = s_q.cap;
    assign mdio_o  = s_q.running & s_q.shreg[FRAME_BITS-1];
    assign mdio_oe = s_q.running & ~(s_q.rd & (s_q.idx >= IDX_W'(TA_FIRST)));
endmodule

// File: rtl/mdio_cmd_regfile.sv
`timescale 1ns/1ps
module mdio_cmd_regfile
    import mdio_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        busy,
    input  logic        done,
    input  logic [15:0] done_data,
    output logic        start,
    output mdio_cmd_t   launch_cmd,
    output logic [31:0] rd_word
);
    mdio_cmd_t c_d, c_q;
    logic      accept;

    always_comb begin
        c_d        = c_q;
        accept     = wr_en && !busy;
        launch_cmd = decode_word(wr_data);
        start      = accept && wr_data[31];
        if (accept)
            c_d = launch_cmd;
        else if (done && c_q.rd)
            c_d.data = done_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rd_word = {busy, c_q.rd, 4'b0000, c_q.phy, c_q.regad, c_q.data};
endmodule

// File: rtl/mdio_cmd_master.sv
`timescale 1ns/1ps
module mdio_cmd_master
    import mdio_cmd_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic        start;
    mdio_cmd_t   launch_cmd;
    logic        running;
    logic        done;
    logic [15:0] cap_data;
    logic        rise_tick;
    logic        fall_tick;

    mdio_cmd_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_data    (reg_wr_data),
        .busy       (running),
        .done       (done),
        .done_data  (cap_data),
        .start      (start),
        .launch_cmd (launch_cmd),
        .rd_word    (reg_rd_data)
    );

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (running),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (launch_cmd),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .running   (running),
        .done      (done),
        .rd_data   (cap_data),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );
endmodule

// File: rtl/mdio_cmd_master_chk.sv
`timescale 1ns/1ps
module mdio_cmd_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [31:0] reg_wr_data,
    input logic [31:0] reg_rd_data,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    logic busy;
    assign busy = reg_rd_data[31];

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_wr_en && reg_wr_data[31]) |=> busy);

    p_no_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_wr_en && !reg_wr_data[31]) |=> !busy);

    p_busy_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr_en) |=> $stable(reg_rd_data[30:16]));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    p_mdio_steady_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_cmd_master mdio_cmd_master_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .mdc         (mdc),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe)
);

// File: tb/mdio_cmd_master_tb_top.sv
`timescale 1ns/1ps
module mdio_cmd_master_tb_top;
    localparam int HALF     = 2;
    localparam int FRAME_CY = 64 * 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mdio_cmd_master #(.HALF_DIV(HALF)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .mdc         (mdc),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .mdio_i      (mdio_i)
    );

    // bus observer and PHY model
    logic [63:0] cap_o  = '0;
    logic [63:0] cap_oe = '0;
    int          rise_cnt  = 0;
    int          rise_base = 0;
    logic [15:0] phy_val   = '0;
    int          high_viol = 0;
    logic        prev_mdc = 1'b0;
    logic        prev_o   = 1'b0;
    logic        prev_oe  = 1'b0;

    always @(posedge mdc) begin
        cap_o    <= {cap_o[62:0], mdio_o};
        cap_oe   <= {cap_oe[62:0], mdio_oe};
        rise_cnt <= rise_cnt + 1;
    end

    always @(negedge mdc) begin
        int idx;
        idx = rise_cnt - rise_base;
        mdio_i <= (idx >= 48 && idx < 64) ? phy_val[63-idx] : 1'b1;
    end

    always @(negedge clk) begin
        if (prev_mdc && mdc && (mdio_o != prev_o || mdio_oe != prev_oe))
            high_viol <= high_viol + 1;
        prev_mdc <= mdc;
        prev_o   <= mdio_o;
        prev_oe  <= mdio_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = w;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (reg_rd_data[31] && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] word(input bit go, input bit rd, input logic [3:0] rsv,
                                         input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        return {go, rd, rsv, phy, ra, d};
    endfunction

    task automatic t_reset;
        chk(reg_rd_data == 32'h0, "R1 word", 64'(reg_rd_data), 64'h0);
        chk(mdc == 1'b0, "R1 mdc", 64'(mdc), 64'h0);
        chk(mdio_oe == 1'b0, "R1 oe", 64'(mdio_oe), 64'h0);
    endtask

    task automatic t_write_frame(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        int cyc;
        logic [63:0] exp;
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, d};
        rise_base = rise_cnt;
        issue(word(1'b1, 1'b0, 4'hF, phy, ra, d));
        chk(reg_rd_data[31] == 1'b1, "R2 busy set", 64'(reg_rd_data[31]), 64'h1);
        wait_idle(cyc);
        chk(cyc == FRAME_CY, "R2 duration", 64'(cyc), 64'(FRAME_CY));
        chk(cap_o == exp, "R3 write frame", cap_o, exp);
        chk(cap_oe == '1, "R3 oe", cap_oe, '1);
        chk(reg_rd_data == {2'b00, 4'h0, phy, ra, d}, "R9 readback",
            64'(reg_rd_data), 64'({2'b00, 4'h0, phy, ra, d}));
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R8 idle", 64'({mdc, mdio_oe}), 64'h0);
    endtask

    task automatic t_read_frame(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] reply);
        int cyc;
        logic [45:0] exp_hdr;
        exp_hdr   = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra};
        phy_val   = reply;
        rise_base = rise_cnt;
        issue(word(1'b1, 1'b1, 4'h0, phy, ra, 16'hFFFF));
        wait_idle(cyc);
        chk(cyc == FRAME_CY, "R2 read duration", 64'(cyc), 64'(FRAME_CY));
        chk(cap_o[63:18] == exp_hdr, "R4 read header", 64'(cap_o[63:18]), 64'(exp_hdr));
        chk(cap_oe == {{46{1'b1}}, 18'h0}, "R4 release", cap_oe, {{46{1'b1}}, 18'h0});
        chk(reg_rd_data[15:0] == reply, "R5 read data", 64'(reg_rd_data[15:0]), 64'(reply));
        chk(reg_rd_data[31:16] == {2'b01, 4'h0, phy, ra}, "R5 fields",
            64'(reg_rd_data[31:16]), 64'({2'b01, 4'h0, phy, ra}));
    endtask

    task automatic t_busy_ignore;
        int cyc;
        int r0;
        logic [63:0] exp;
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h06, 5'h11, 2'b10, 16'h1234};
        rise_base = rise_cnt;
        issue(word(1'b1, 1'b0, 4'h0, 5'h06, 5'h11, 16'h1234));
        repeat (20) @(negedge clk);
        issue(word(1'b1, 1'b1, 4'h0, 5'h19, 5'h02, 16'hBEEF));
        chk(reg_rd_data[30:16] == {1'b0, 4'h0, 5'h06, 5'h11}, "R6 fields held",
            64'(reg_rd_data[30:16]), 64'({1'b0, 4'h0, 5'h06, 5'h11}));
        wait_idle(cyc);
        chk(cap_o == exp, "R6 frame intact", cap_o, exp);
        chk(reg_rd_data == {2'b00, 4'h0, 5'h06, 5'h11, 16'h1234}, "R6 word",
            64'(reg_rd_data), 64'({2'b00, 4'h0, 5'h06, 5'h11, 16'h1234}));
        r0 = rise_cnt;
        repeat (60) @(negedge clk);
        chk(rise_cnt == r0 && !reg_rd_data[31], "R6 no second frame", 64'(rise_cnt), 64'(r0));
    endtask

    task automatic t_no_launch;
        int r0;
        r0 = rise_cnt;
        issue(word(1'b0, 1'b1, 4'hA, 5'h0C, 5'h1B, 16'h5A5A));
        repeat (40) @(negedge clk);
        chk(rise_cnt == r0 && mdc == 1'b0, "R7 no mdc", 64'(rise_cnt), 64'(r0));
        chk(reg_rd_data == {2'b01, 4'h0, 5'h0C, 5'h1B, 16'h5A5A}, "R7 stored",
            64'(reg_rd_data), 64'({2'b01, 4'h0, 5'h0C, 5'h1B, 16'h5A5A}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write_frame(5'h13, 5'h0A, 16'hA53C);
        t_read_frame(5'h1F, 5'h00, 16'hC3A5);
        t_read_frame(5'h00, 5'h1F, 16'h0001);
        t_write_frame(5'h01, 5'h10, 16'h8000);
        t_busy_ignore();
        t_no_launch();
        t_read_frame(5'h15, 5'h0B, 16'h8001);
        chk(high_viol == 0, "R8 stable while mdc high", 64'(high_viol), 64'h0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule